// File: doc/BRIEF.md
# Capture Memory Readback Sequencer

Once a logic-capture run has filled the sample memory, this block drains that memory to a host over a two-wire serial link. A host request is honoured only after the capture side reports that both half-rate sample clocks have stopped. The block then tears down the capture path in a fixed order. The sample clock is gated off, the external capture counters and the block's own address counter are cleared, and the probe latches stop driving the shared data bus. Only after that is the memory's read output turned on.

The memory is then read at every address in ascending order. For each address the output enable is held for one access cycle, and then the byte is parallel-loaded into a shift register. The byte leaves most-significant bit first, one bit per serial clock pulse. After the last address the block raises a finished flag and waits for the host to drop its request, which serves as the acknowledge. It then pulses the capture reset once, releases the latches and re-enables the sample clock.

The state sequence is IDLE → HALT (clock off) → CLR (counters cleared) → RELEASE (latches off) → ACCESS (read enable, access time) → LOAD (byte into shift register) → SHIFT_LO / SHIFT_HI (one serial bit per pair). From SHIFT_HI the block returns to SHIFT_LO for the next bit. It goes to ACCESS at a new address when the byte is complete, and to DONE after the final byte of the last address. DONE holds the finished flag. When the request drops, it moves to RESTORE (capture reset) and then back to IDLE.

Top module: `capmem_readback`

## Requirements
- R1: During and right after reset, and in IDLE, the outputs are: smp_clk_en=1, latch_oe=1, sram_oe=0, cap_ctr_clr=0, sclk=0, finished=0. A reset during a readback returns the block to this state.
- R2: host_start has no effect while cap_done is low, and cap_done alone has no effect without host_start. In both cases the outputs stay as in R1.
- R3: Teardown happens in four strictly later cycles, in this order: smp_clk_en falls, then cap_ctr_clr pulses, then latch_oe falls, then sram_oe rises. The sample clock stays off whenever sram_oe is high.
- R4: sram_oe and latch_oe are never high in the same cycle.
- R5: For every address, sram_oe is high with a stable address for one full cycle before the cycle in which the byte is loaded. Each rise of sram_oe lasts at least two cycles.
- R6: Each byte is sent MSB first as DATA_W high pulses of sclk. Each pulse is one cycle high after one cycle low. sdata does not change on the cycle sclk rises.
- R7: Addresses 0 to 2^ADDR_W-1 are sent in ascending order, one byte each, and sram_addr is stable while sclk is high.
- R8: After the last byte, finished goes high and stays high for as long as host_start is held high. sram_oe is low in this state.
- R9: The cycle after host_start drops in DONE, cap_ctr_clr pulses while finished, sram_oe, latch_oe and smp_clk_en are all low. In the cycle after that, the block is back at the R1 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_done | input | 1 | Capture side has stopped both half-rate sample clocks |
| host_start | input | 1 | Host readback request; dropping it acknowledges finished |
| finished | output | 1 | All addresses have been sent |
| smp_clk_en | output | 1 | Sample clock enable toward the capture path |
| cap_ctr_clr | output | 1 | One-cycle clear for the capture counters |
| latch_oe | output | 1 | Output enable of the probe latches onto the data bus |
| sram_oe | output | 1 | Sample memory read output enable |
| sram_addr | output | ADDR_W | Sample memory read address |
| sram_data | input | DATA_W | Sample memory read data |
| sclk | output | 1 | Serial clock to host; data valid while high |
| sdata | output | 1 | Serial data to host |

## Verification
The checker takes for granted that host_start, once raised, stays high until finished appears. It also assumes that sram_data settles within one cycle of a stable address with the enable on. The bench's memory model enforces that second assumption strictly: it returns a wrong value whenever the enable or the address is new in the current cycle. A byte loaded without the access cycle is therefore caught by comparing the received data. The stimulus holds the request through each whole readback and changes inputs only at falling clock edges. It deasserts the request only after finished has been observed, apart from one deliberate reset issued in the middle of a shift.

// File: rtl/capmem_pkg.sv
package capmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_CLR,
        ST_RELEASE,
        ST_ACCESS,
        ST_LOAD,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_DONE,
        ST_RESTORE
    } rb_state_e;

endpackage

// File: rtl/capmem_addr_ctr.sv
module capmem_addr_ctr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = &addr;

endmodule

// File: rtl/capmem_piso.sv
module capmem_piso #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              sout,
    output logic              last_bit
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (load) begin
            shreg <= din;
            bcnt  <= '0;
        end else if (shift) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
        end
    end

    assign sout     = shreg[DATA_W-1];
    assign last_bit = (bcnt == LAST_IDX);

endmodule

// File: rtl/capmem_fsm.sv
module capmem_fsm
    import capmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_done,
    input  logic host_start,
    input  logic last_bit,
    input  logic at_last,
    output logic smp_clk_en,
    output logic cap_ctr_clr,
    output logic latch_oe,
    output logic sram_oe,
    output logic sclk,
    output logic finished,
    output logic addr_clr,
    output logic addr_inc,
    output logic piso_load,
    output logic piso_shift
);

    rb_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cap_done && host_start) state_nx = ST_HALT;
            ST_HALT:     state_nx = ST_CLR;
            ST_CLR:      state_nx = ST_RELEASE;
            ST_RELEASE:  state_nx = ST_ACCESS;
            ST_ACCESS:   state_nx = ST_LOAD;
            ST_LOAD:     state_nx = ST_SHIFT_LO;
            ST_SHIFT_LO: state_nx = ST_SHIFT_HI;
            ST_SHIFT_HI: begin
                if (!last_bit)     state_nx = ST_SHIFT_LO;
                else if (at_last)  state_nx = ST_DONE;
                else               state_nx = ST_ACCESS;
            end
            ST_DONE:     if (!host_start) state_nx = ST_RESTORE;
            ST_RESTORE:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        smp_clk_en  = 1'b0;
        cap_ctr_clr = 1'b0;
        latch_oe    = 1'b0;
        sram_oe     = 1'b0;
        sclk        = 1'b0;
        finished    = 1'b0;
        addr_clr    = 1'b0;
        addr_inc    = 1'b0;
        piso_load   = 1'b0;
        piso_shift  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                smp_clk_en = 1'b1;
                latch_oe   = 1'b1;
            end
            ST_HALT: begin
                latch_oe   = 1'b1;
            end
            ST_CLR: begin
                latch_oe    = 1'b1;
                cap_ctr_clr = 1'b1;
                addr_clr    = 1'b1;
            end
            ST_RELEASE: begin
            end
            ST_ACCESS: begin
                sram_oe = 1'b1;
            end
            ST_LOAD: begin
                sram_oe   = 1'b1;
                piso_load = 1'b1;
            end
            ST_SHIFT_LO: begin
                sram_oe = 1'b1;
            end
            ST_SHIFT_HI: begin
                sram_oe    = 1'b1;
                sclk       = 1'b1;
                piso_shift = 1'b1;
                addr_inc   = last_bit && !at_last;
            end
            ST_DONE: begin
                finished = 1'b1;
            end
            ST_RESTORE: begin
                cap_ctr_clr = 1'b1;
                addr_clr    = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/capmem_readback.sv
module capmem_readback #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_done,
    input  logic              host_start,
    output logic              finished,
    output logic              smp_clk_en,
    output logic              cap_ctr_clr,
    output logic              latch_oe,
    output logic              sram_oe,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [DATA_W-1:0] sram_data,
    output logic              sclk,
    output logic              sdata
);

    logic last_bit;
    logic at_last;
    logic addr_clr;
    logic addr_inc;
    logic piso_load;
    logic piso_shift;

    capmem_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_done    (cap_done),
        .host_start  (host_start),
        .last_bit    (last_bit),
        .at_last     (at_last),
        .smp_clk_en  (smp_clk_en),
        .cap_ctr_clr (cap_ctr_clr),
        .latch_oe    (latch_oe),
        .sram_oe     (sram_oe),
        .sclk        (sclk),
        .finished    (finished),
        .addr_clr    (addr_clr),
        .addr_inc    (addr_inc),
        .piso_load   (piso_load),
        .piso_shift  (piso_shift)
    );

    capmem_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .addr    (sram_addr),
        .at_last (at_last)
    );

    capmem_piso #(.DATA_W(DATA_W)) u_piso (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (piso_load),
        .shift    (piso_shift),
        .din      (sram_data),
        .sout     (sdata),
        .last_bit (last_bit)
    );

endmodule

// File: rtl/capmem_readback_chk.sv
module capmem_readback_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_start,
    input logic              finished,
    input logic              smp_clk_en,
    input logic              cap_ctr_clr,
    input logic              latch_oe,
    input logic              sram_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sclk,
    input logic              sdata
);

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sram_oe && latch_oe)); // R4
    AST_CLK_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n) sram_oe |-> !smp_clk_en); // R3
    AST_OE_LEAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sram_oe) |=> sram_oe); // R5
    AST_SDATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(sdata)); // R6
    AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sclk |=> !sclk); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(sram_addr)); // R7
    AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (finished && host_start) |=> finished); // R8
    AST_FIN_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) finished |-> !sram_oe); // R8
    AST_RESTORE_CLR: assert property (@(posedge clk) disable iff (!rst_n) $fell(finished) |-> (cap_ctr_clr && !smp_clk_en)); // R9
    AST_RESTORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(finished) && !finished) |=> (smp_clk_en && latch_oe)); // R9

endmodule

bind capmem_readback capmem_readback_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_start  (host_start),
    .finished    (finished),
    .smp_clk_en  (smp_clk_en),
    .cap_ctr_clr (cap_ctr_clr),
    .latch_oe    (latch_oe),
    .sram_oe     (sram_oe),
    .sram_addr   (sram_addr),
    .sclk        (sclk),
    .sdata       (sdata)
);

// File: tb/tb_capmem_readback.sv
module tb_capmem_readback;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [7:0] seed;
        int         pre;
        int         hold;
        int         exp_bytes;
    } vec_t;

    localparam int NVEC = 3;
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 0, 1, DEPTH},
        '{8'h5A, 3, 4, DEPTH},
        '{8'hC3, 7, 9, DEPTH}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_done = 1'b0;
    logic          host_start = 1'b0;
    logic          finished, smp_clk_en, cap_ctr_clr, latch_oe, sram_oe, sclk, sdata;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    capmem_readback #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_done    (cap_done),
        .host_start  (host_start),
        .finished    (finished),
        .smp_clk_en  (smp_clk_en),
        .cap_ctr_clr (cap_ctr_clr),
        .latch_oe    (latch_oe),
        .sram_oe     (sram_oe),
        .sram_addr   (sram_addr),
        .sram_data   (sram_data),
        .sclk        (sclk),
        .sdata       (sdata)
    );

    function automatic logic [7:0] patt(input logic [AW-1:0] a, input logic [7:0] s);
        logic [7:0] p;
        p = {4'b0, a} * 8'd29;
        return p ^ s ^ 8'h3C;
    endfunction

    // memory model: data only valid after enable and address were steady one cycle
    logic [7:0]    seed_cur = 8'h00;
    logic [AW-1:0] prev_addr = '0;
    logic          prev_oe = 1'b0;
    always @(posedge clk) begin
        prev_addr <= sram_addr;
        prev_oe   <= sram_oe;
        cyc       <= cyc + 1;
    end
    assign sram_data = (sram_oe && prev_oe && prev_addr == sram_addr) ?
                       patt(sram_addr, seed_cur) : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // serial monitor
    bit         run_active = 0;
    logic [7:0] acc = '0;
    int         nbits = 0;
    int         nbytes = 0;
    int         t_off = -1, t_clr = -1, t_rel = -1, t_oe = -1;

    always @(negedge clk) begin
        if (rst_n && run_active) begin
            if (t_off < 0 && !smp_clk_en) t_off = cyc;
            if (t_clr < 0 && cap_ctr_clr) t_clr = cyc;
            if (t_rel < 0 && !latch_oe)   t_rel = cyc;
            if (t_oe < 0 && sram_oe)      t_oe = cyc;
            chk(!(sram_oe && latch_oe), "R4", {sram_oe, latch_oe}, 0);
            if (sclk) begin
                acc = {acc[6:0], sdata};
                nbits++;
                if (nbits == DW) begin
                    chk(acc == patt(sram_addr, seed_cur), "R6", acc, patt(sram_addr, seed_cur));
                    chk(sram_addr == nbytes[AW-1:0], "R7", sram_addr, nbytes);
                    nbytes++;
                    nbits = 0;
                end
            end
        end
    end

    task automatic mon_reset();
        acc = '0; nbits = 0; nbytes = 0;
        t_off = -1; t_clr = -1; t_rel = -1; t_oe = -1;
    endtask

    task automatic check_idle(input string req);
        chk(smp_clk_en && latch_oe && !sram_oe && !cap_ctr_clr && !sclk && !finished, req,
            {smp_clk_en, latch_oe, sram_oe, cap_ctr_clr, sclk, finished}, 6'b110000);
    endtask

    // watchdog
    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R2: request without capture done, and done without request
        host_start = 1'b1;
        repeat (8) @(negedge clk);
        check_idle("R2");
        host_start = 1'b0;
        cap_done = 1'b1;
        repeat (8) @(negedge clk);
        check_idle("R2");
        cap_done = 1'b0;
        @(negedge clk);

        // table-driven full readbacks
        for (int v = 0; v < NVEC; v++) begin
            int n;
            seed_cur = VEC[v].seed;
            mon_reset();
            run_active = 1;
            cap_done = 1'b1;
            repeat (VEC[v].pre) @(negedge clk);
            host_start = 1'b1;
            n = 0;
            while (!finished && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk(finished, "R8", finished, 1);
            chk(nbytes == VEC[v].exp_bytes, "R7", nbytes, VEC[v].exp_bytes);
            chk(t_off >= 0 && t_clr > t_off && t_rel > t_clr && t_oe > t_rel, "R3",
                t_oe - t_off, 3);
            chk(t_oe - t_rel >= 1, "R5", t_oe - t_rel, 1);
            repeat (VEC[v].hold) @(negedge clk);
            chk(finished && !sram_oe && !latch_oe && !smp_clk_en, "R8",
                {finished, sram_oe, latch_oe, smp_clk_en}, 4'b1000);
            host_start = 1'b0;
            cap_done = 1'b0;
            @(negedge clk);
            chk(cap_ctr_clr && !finished && !sram_oe && !latch_oe && !smp_clk_en, "R9",
                {cap_ctr_clr, finished, sram_oe, latch_oe, smp_clk_en}, 5'b10000);
            @(negedge clk);
            check_idle("R9");
            run_active = 0;
            @(negedge clk);
        end

        // R1: reset in the middle of a shift
        seed_cur = 8'h11;
        cap_done = 1'b1;
        host_start = 1'b1;
        begin
            int n;
            n = 0;
            while (!sclk && n < 200) begin
                @(negedge clk);
                n++;
            end
        end
        chk(sclk, "R6", sclk, 1);
        rst_n = 1'b0;
        #2;
        check_idle("R1");
        host_start = 1'b0;
        cap_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R2: after recovery, a request without done still does nothing
        host_start = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R2");
        host_start = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule